// File: doc/BRIEF.md
# Line-Idle Serial Frame Receiver

This block sits behind a byte-wide UART receiver and turns its stream of characters into frames. A frame has no length field and no end marker on the wire: it ends only when the line has been quiet long enough. Each byte restarts a silence timer measured in microsecond ticks. When the timer reaches the end-of-frame timeout, the block reports the frame length and a bad-frame code with a one-cycle event. It then holds that result, and ignores the line, until the frame processor sends a restart pulse.

Good bytes are written in arrival order through a write port into an external frame buffer. Bytes that carry a line error, and bytes that arrive when the buffer is full, are not written, and they mark the whole frame bad. The microsecond tick is a port so the transmit side can pace itself from the same counter. After a frame closes, the silence timer keeps running and reports the moment the full inter-frame gap has passed, so a reply can be started no earlier than that.

The timeout and the gap both depend on the baud rate. At 19200 baud or slower they are 1.5 and 3.5 character times, where one character is 11 bit times, rounded down to whole microseconds. At any faster rate they are fixed at 750 µs and 1750 µs.

Top module: `serial_frame_rx`

## Requirements
- R1: `us_tick` is high for one clock out of every `CLK_PER_US` clocks. While bytes are arriving, its phase restarts from each accepted byte.
- R2: With `BAUD` ≤ 19200, `frame_done` pulses for exactly one cycle. It is first high `TIMEOUT_US*CLK_PER_US` clocks after the clock edge that accepted the last byte, where TIMEOUT_US = floor(16500000/BAUD).
- R3: With `BAUD` > 19200, the timeout is 750 µs and the inter-frame gap is 1750 µs, whatever the baud rate.
- R4: `gap_ok` pulses once, `GAP_US*CLK_PER_US` clocks after the edge that accepted the last byte. GAP_US = floor(38500000/BAUD) at 19200 baud or below.
- R5: Every byte accepted while receiving restarts the silence timer. This includes errored and dropped bytes. A byte that arrives one clock before expiry postpones `frame_done`.
- R6: A byte with any of `rx_err_framing`, `rx_err_overrun` or `rx_err_noise` set is not written and sets `frame_bad` to 1.
- R7: A good byte that arrives when `BUF_DEPTH` bytes are already held is not written, and it sets `frame_bad` to 2. If a frame has more than one bad cause, the last one wins. Codes: 0 = clean, 1 = line error, 2 = overflow.
- R8: A stored byte appears on `buf_we`/`buf_addr`/`buf_wdata` one clock after it is accepted. `buf_addr` is its index in the frame, starting at 0. `frame_start` pulses together with the write of index 0 only.
- R9: `idle` is high only while receiving with zero bytes stored. It stays high after an errored first byte, and it is low after frame end even when the frame holds no bytes.
- R10: After `frame_done`, bytes are ignored: no write, and `frame_len` and `frame_bad` stay unchanged. A `restart` pulse clears the length and the bad code, disarms the timer and resumes reception. A restart in the middle of a frame drops that frame without a `frame_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_err_framing | input | 1 | Stop-bit error on this character |
| rx_err_overrun | input | 1 | Receiver overrun on this character |
| rx_err_noise | input | 1 | Noise detected on this character |
| restart | input | 1 | Frame processor is done; clear and receive again |
| us_tick | output | 1 | Microsecond tick, shared with the transmit side |
| buf_we | output | 1 | Frame buffer write enable |
| buf_addr | output | ADDR_W | Frame buffer write index |
| buf_wdata | output | 8 | Frame buffer write data |
| frame_start | output | 1 | First byte of a frame stored |
| frame_done | output | 1 | Frame closed by silence (one cycle) |
| frame_len | output | LEN_W | Bytes stored in the current frame |
| frame_bad | output | 2 | Bad-frame code (0 clean, 1 line error, 2 overflow) |
| gap_ok | output | 1 | Inter-frame gap has elapsed since the last byte |
| idle | output | 1 | Receiving with an empty frame |

## Verification
The hardest case to reach is the boundary of the silence timer. A byte has to land on the single clock before expiry, where it must postpone the frame end and must not close it. The stimulus spaces bytes exactly one clock inside the timeout and counts clocks from the accepting edge. This lets a timer that is off by one, or a missed restart, show up as a wrong cycle number. Buffer overflow is reached with a small buffer and frames longer than it, sent in both orders with a line error, to check that the last cause sets the code.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    // Character on the wire: start + 8 data + parity + stop
    localparam int CHAR_BITS      = 11;
    localparam int SLOW_BAUD_MAX  = 19200;
    localparam int FAST_TIMEOUT   = 750;
    localparam int FAST_GAP       = 1750;

    typedef enum logic [1:0] {
        BAD_NONE     = 2'd0,
        BAD_LINE     = 2'd1,
        BAD_OVERFLOW = 2'd2
    } bad_code_e;

    typedef enum logic {
        ST_RECV = 1'b0,
        ST_HOLD = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       err;
    } rx_byte_t;

    // Half character times -> microseconds, rounded down
    function automatic int half_chars_us(input int halves, input int baud);
        return (1000000 * CHAR_BITS * halves / 2) / baud;
    endfunction

    function automatic int timeout_us(input int baud);
        if (baud <= SLOW_BAUD_MAX) return half_chars_us(3, baud);
        return FAST_TIMEOUT;
    endfunction

    function automatic int gap_us(input int baud);
        if (baud <= SLOW_BAUD_MAX) return half_chars_us(7, baud);
        return FAST_GAP;
    endfunction

endpackage

// File: rtl/sfr_us_prescaler.sv
module sfr_us_prescaler #(
    parameter int CLK_PER_US = 100,
    localparam int PW = $clog2(CLK_PER_US + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_clr,
    output logic tick
);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || sync_clr)  cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    assert_pre_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    generate
        if (CLK_PER_US > 1) begin : g_spacing
            assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sfr_silence_timer.sv
module sfr_silence_timer #(
    parameter int TIMEOUT_US = 859,
    parameter int GAP_US     = 2005,
    localparam int SW = $clog2(GAP_US + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    input  logic clr,
    input  logic tick,
    output logic expire,
    output logic gap_ok
);
    localparam logic [SW-1:0] TO_LAST  = SW'(TIMEOUT_US - 1);
    localparam logic [SW-1:0] GAP_LAST = SW'(GAP_US - 1);
    localparam logic [SW-1:0] GAP_END  = SW'(GAP_US);

    logic [SW-1:0] sil;
    logic          armed;
    logic          step;
    logic          gap_hit;

    assign step    = armed && tick;
    assign expire  = step && (sil == TO_LAST);
    assign gap_hit = step && (sil == GAP_LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sil   <= '0;
            armed <= 1'b0;
        end else if (kick) begin
            sil   <= '0;
            armed <= 1'b1;
        end else if (step && sil != GAP_END) begin
            sil <= sil + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) gap_ok <= 1'b0;
        else     gap_ok <= gap_hit && !kick && !clr;
    end

    assert_sil_cap_R4: assert property (@(posedge clk) disable iff (rst)
        sil <= GAP_END);

    assert_gap_once_R4: assert property (@(posedge clk) disable iff (rst)
        gap_ok |=> !gap_ok);

    assert_kick_restarts_R5: assert property (@(posedge clk) disable iff (rst)
        kick && !clr |=> sil == '0 && armed);
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
    import sfr_pkg::*;
#(
    parameter int BUF_DEPTH = 256,
    parameter int AW = 8,
    parameter int LW = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  rx_byte_t       in_byte,
    input  logic           in_vld,
    input  logic           restart,
    input  logic           expire,
    output logic           accept,
    output logic           buf_we,
    output logic [AW-1:0]  buf_addr,
    output logic [7:0]     buf_wdata,
    output logic           frame_start,
    output logic           frame_done,
    output logic [LW-1:0]  frame_len,
    output bad_code_e      frame_bad,
    output logic           idle
);
    localparam logic [LW-1:0] FULL = LW'(BUF_DEPTH);

    rx_state_e st;

    assign accept = (st == ST_RECV) && in_vld && !restart;
    assign idle   = (st == ST_RECV) && (frame_len == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_RECV;
            frame_len   <= '0;
            frame_bad   <= BAD_NONE;
            buf_we      <= 1'b0;
            buf_addr    <= '0;
            buf_wdata   <= '0;
            frame_start <= 1'b0;
            frame_done  <= 1'b0;
        end else begin
            buf_we      <= 1'b0;
            frame_start <= 1'b0;
            frame_done  <= 1'b0;
            if (restart) begin
                st        <= ST_RECV;
                frame_len <= '0;
                frame_bad <= BAD_NONE;
            end else if (accept) begin
                if (in_byte.err) begin
                    frame_bad <= BAD_LINE;
                end else if (frame_len < FULL) begin
                    buf_we      <= 1'b1;
                    buf_addr    <= AW'(frame_len);
                    buf_wdata   <= in_byte.data;
                    frame_len   <= frame_len + 1'b1;
                    frame_start <= (frame_len == '0);
                end else begin
                    frame_bad <= BAD_OVERFLOW;
                end
            end else if (st == ST_RECV && expire) begin
                st         <= ST_HOLD;
                frame_done <= 1'b1;
            end
        end
    end

    assert_len_bound_R7: assert property (@(posedge clk) disable iff (rst)
        frame_len <= FULL);

    assert_start_first_R8: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> buf_we && buf_addr == '0);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_hold_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        st == ST_HOLD && !restart |=> $stable(frame_len) && $stable(frame_bad) && !buf_we);

    assert_done_not_idle_R9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !idle);
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int BAUD       = 19200,
    parameter int BUF_DEPTH  = 256,
    localparam int ADDR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
    localparam int LEN_W  = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_err_framing,
    input  logic              rx_err_overrun,
    input  logic              rx_err_noise,
    input  logic              restart,
    output logic              us_tick,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              frame_start,
    output logic              frame_done,
    output logic [LEN_W-1:0]  frame_len,
    output logic [1:0]        frame_bad,
    output logic              gap_ok,
    output logic              idle
);
    localparam int TO_US  = timeout_us(BAUD);
    localparam int GAP_US = gap_us(BAUD);

    rx_byte_t  in_byte;
    logic      accept;
    logic      expire;
    bad_code_e bad_code;

    assign in_byte.data = rx_data;
    assign in_byte.err  = rx_err_framing | rx_err_overrun | rx_err_noise;
    assign frame_bad    = bad_code;

    sfr_us_prescaler #(.CLK_PER_US(CLK_PER_US)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .sync_clr (accept),
        .tick     (us_tick)
    );

    sfr_silence_timer #(.TIMEOUT_US(TO_US), .GAP_US(GAP_US)) u_sil (
        .clk    (clk),
        .rst    (rst),
        .kick   (accept),
        .clr    (restart),
        .tick   (us_tick),
        .expire (expire),
        .gap_ok (gap_ok)
    );

    sfr_frame_ctrl #(.BUF_DEPTH(BUF_DEPTH), .AW(ADDR_W), .LW(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_byte     (in_byte),
        .in_vld      (rx_valid),
        .restart     (restart),
        .expire      (expire),
        .accept      (accept),
        .buf_we      (buf_we),
        .buf_addr    (buf_addr),
        .buf_wdata   (buf_wdata),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .frame_len   (frame_len),
        .frame_bad   (bad_code),
        .idle        (idle)
    );

    assert_err_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid && in_byte.err && !restart |=> !buf_we);
endmodule

// File: tb/serial_frame_rx_test.sv
module serial_frame_rx_test;
    localparam int P     = 2;
    localparam int BAUD  = 19200;
    localparam int DEPTH = 8;
    localparam int AW    = 3;
    localparam int LW    = 4;
    localparam int TO_US = (BAUD <= 19200) ? (1000000 * 11 * 3 / 2) / BAUD : 750;
    localparam int GP_US = (BAUD <= 19200) ? (1000000 * 11 * 7 / 2) / BAUD : 1750;
    localparam int TO_CYC  = TO_US * P;
    localparam int GAP_CYC = GP_US * P;
    localparam int HI_BAUD = 19201;
    localparam int HI_TO   = 750;
    localparam int HI_GAP  = 1750;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, rx_valid, efr, eov, enz, restart;
    logic [7:0] rx_data;
    logic us_tick, buf_we, frame_start, frame_done, gap_ok, idle;
    logic [AW-1:0] buf_addr;
    logic [7:0] buf_wdata;
    logic [LW-1:0] frame_len;
    logic [1:0] frame_bad;

    logic hv;
    logic [7:0] hd;
    logic h_tick, h_we, h_start, h_done, h_gap, h_idle;
    logic [7:0] h_addr;
    logic [7:0] h_wdata;
    logic [8:0] h_len;
    logic [1:0] h_bad;

    serial_frame_rx #(.CLK_PER_US(P), .BAUD(BAUD), .BUF_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err_framing(efr), .rx_err_overrun(eov), .rx_err_noise(enz),
        .restart(restart), .us_tick(us_tick), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .frame_start(frame_start), .frame_done(frame_done),
        .frame_len(frame_len), .frame_bad(frame_bad), .gap_ok(gap_ok), .idle(idle)
    );

    serial_frame_rx #(.CLK_PER_US(1), .BAUD(HI_BAUD), .BUF_DEPTH(256)) uut_hi (
        .clk(clk), .rst(rst), .rx_valid(hv), .rx_data(hd),
        .rx_err_framing(1'b0), .rx_err_overrun(1'b0), .rx_err_noise(1'b0),
        .restart(1'b0), .us_tick(h_tick), .buf_we(h_we), .buf_addr(h_addr),
        .buf_wdata(h_wdata), .frame_start(h_start), .frame_done(h_done),
        .frame_len(h_len), .frame_bad(h_bad), .gap_ok(h_gap), .idle(h_idle)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] e);
        rx_valid = 1'b1;
        rx_data  = d;
        {efr, eov, enz} = e;
        @(negedge clk);
        rx_valid = 1'b0;
        {efr, eov, enz} = 3'b000;
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (frame_done) seen++;
        end
        chk(tag, seen, 0);
    endtask

    task automatic wait_end(input int limit, output int done_at, output int gap_at, output int pulses);
        done_at = -1; gap_at = -1; pulses = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (frame_done) begin
                if (done_at < 0) done_at = k;
                pulses++;
            end
            if (gap_ok && gap_at < 0) gap_at = k;
        end
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d_at, g_at, np, ticks;
        rst = 1'b1; rx_valid = 1'b0; rx_data = '0; efr = 0; eov = 0; enz = 0;
        restart = 1'b0; hv = 1'b0; hd = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state
        chk("R9 reset idle", idle, 1);
        chk("R2 reset frame_done", frame_done, 0);
        chk("R10 reset len", frame_len, 0);
        chk("R6 reset bad", frame_bad, 0);
        chk("R8 reset buf_we", buf_we, 0);

        // R1: tick rate
        ticks = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); ticks += us_tick; end
        chk("R1 tick count P=2", ticks, 20 / P);
        ticks = 0;
        for (int k = 0; k < 20; k++) begin @(negedge clk); ticks += h_tick; end
        chk("R1 tick count P=1", ticks, 20);

        // Frame A: three bytes, spaced one clock inside the timeout
        for (int i = 0; i < 3; i++) begin
            send(8'h11 * (i + 1), 3'b000);
            chk("R8 write enable", buf_we, 1);
            chk("R8 write index", buf_addr, i);
            chk("R8 write data", buf_wdata, 8'h11 * (i + 1));
            chk("R8 frame_start only first", frame_start, (i == 0) ? 1 : 0);
            chk("R9 not idle with bytes", idle, 0);
            if (i < 2) quiet(TO_CYC - 2, "R5 no end before restart boundary");
        end
        wait_end(GAP_CYC + 5, d_at, g_at, np);
        chk("R2 timeout cycle", d_at, TO_CYC);
        chk("R2 single done pulse", np, 1);
        chk("R4 gap cycle", g_at, GAP_CYC);
        chk("R10 length held", frame_len, 3);
        chk("R6 clean frame code", frame_bad, 0);
        chk("R9 not idle in hold", idle, 0);

        // R10: byte in hold is ignored
        send(8'hEE, 3'b000);
        chk("R10 no write in hold", buf_we, 0);
        chk("R10 no start in hold", frame_start, 0);
        quiet(5, "R10 no second done");
        chk("R10 length unchanged", frame_len, 3);
        do_restart();
        chk("R10 restart clears len", frame_len, 0);
        chk("R10 restart clears bad", frame_bad, 0);
        chk("R9 idle after restart", idle, 1);

        // R6: each line error kind
        for (int e = 0; e < 3; e++) begin
            send(8'hA0, 3'b000);
            send(8'h55, 3'b001 << e);
            chk("R6 errored byte not written", buf_we, 0);
            send(8'hA1, 3'b000);
            chk("R6 next index skips error", buf_addr, 1);
            wait_end(TO_CYC + 2, d_at, g_at, np);
            chk("R5 timer from last byte", d_at, TO_CYC);
            chk("R6 len excludes errored", frame_len, 2);
            chk("R6 line error code", frame_bad, 1);
            do_restart();
        end

        // R9/R5: frame made only of an errored byte
        send(8'h00, 3'b100);
        chk("R9 idle after errored first byte", idle, 1);
        wait_end(TO_CYC + 2, d_at, g_at, np);
        chk("R5 errored byte arms timer", d_at, TO_CYC);
        chk("R9 not idle in empty hold", idle, 0);
        chk("R6 code on empty frame", frame_bad, 1);
        do_restart();

        // R7: overflow
        for (int i = 0; i < DEPTH + 2; i++) begin
            send(8'(i + 3), 3'b000);
            if (i < DEPTH) chk("R8 fill index", buf_addr, i);
            else           chk("R7 overflow not written", buf_we, 0);
        end
        wait_end(TO_CYC + 2, d_at, g_at, np);
        chk("R7 len capped", frame_len, DEPTH);
        chk("R7 overflow code", frame_bad, 2);
        do_restart();

        // R7: overflow then line error -> 1
        for (int i = 0; i < DEPTH + 1; i++) send(8'(i), 3'b000);
        send(8'h77, 3'b010);
        wait_end(TO_CYC + 2, d_at, g_at, np);
        chk("R7 last cause line error", frame_bad, 1);
        do_restart();

        // R7: line error then overflow -> 2
        send(8'h77, 3'b010);
        for (int i = 0; i < DEPTH + 1; i++) send(8'(i), 3'b000);
        wait_end(TO_CYC + 2, d_at, g_at, np);
        chk("R7 last cause overflow", frame_bad, 2);
        do_restart();

        // R10: restart mid-frame drops it
        send(8'h42, 3'b000);
        send(8'h43, 3'b000);
        do_restart();
        chk("R10 mid restart len", frame_len, 0);
        chk("R9 mid restart idle", idle, 1);
        quiet(TO_CYC + 10, "R10 dropped frame has no done");

        // R3: fast rate instance
        hv = 1'b1; hd = 8'h5A;
        @(negedge clk);
        hv = 1'b0;
        d_at = -1; g_at = -1;
        for (int k = 1; k <= HI_GAP + 5; k++) begin
            @(negedge clk);
            if (h_done && d_at < 0) d_at = k;
            if (h_gap && g_at < 0) g_at = k;
        end
        chk("R3 fast timeout", d_at, HI_TO);
        chk("R3 fast gap", g_at, HI_GAP);
        chk("R3 fast len", h_len, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule